// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block controls a bank of up to 32 pins through a word-wide register port. Software sets each pin on its own to one of three roles: a plain input, a driven output, or an interrupt source. An interrupt source can be level or edge sensitive. A polarity bit chooses the active level or edge, and a dual-edge bit makes both transitions count. Each pin latches its own event, and all enabled pins are merged into a single request line.

Every register access is complete in the cycle in which `bus_sel` is high. Writes take effect at the next rising edge. Read data depends only on the address and appears on `bus_rdata` in the same cycle. The port never stalls, so it needs no ready signal and applies no back-pressure. Pad inputs pass through a two-stage synchroniser before any read-back or event detection uses them.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0 and `irq` is 0, so all pins start as plain inputs with nothing pending and nothing enabled.
- R2: A pin drives (`pad_oe` bit 1) only when its direction bit (offset 0x04) is 1 and its mode bit (offset 0x00) is 0. A mode bit of 1 makes the pin an interrupt source and turns its driver off. `pad_out` always carries the output-data register (offset 0x08), so a value written while the pin is an input appears on the pad as soon as the direction bit is set.
- R3: Reading offset 0x0C returns the output-data bit for each driving pin and the synchronised pad for every other pin. A pad change becomes visible after two rising edges and not after one.
- R4: A pin with mode bit 1 and edge-select bit 1 (offset 0x24) latches a status bit (read at 0x10). With polarity bit 0 (offset 0x20) a rising edge sets it. With polarity bit 1 a falling edge sets it. The opposite edge does nothing.
- R5: When an edge-sensitive interrupt pin has its dual-edge bit (offset 0x4C) set to 1, both a rising and a falling edge set its status, whatever its polarity bit.
- R6: A pin with mode bit 1 and edge-select bit 0 is level sensitive. Its status equals the synchronised pad XOR its polarity bit, and a clear write has no lasting effect on it.
- R7: Writing 1 to a bit of offset 0x14 clears that pin's latched edge status, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the status stays set.
- R8: A write to offset 0x18 clears every mask bit written as 0 and keeps every bit written as 1. A write to offset 0x1C sets every mask bit written as 1. Offset 0x18 reads back the mask.
- R9: `irq` is 1 exactly when some pin has both its status bit and its mask bit set.
- R10: Pins with mode bit 0 never show status. Offsets 0x14, 0x1C, 0x28 and all unlisted offsets read as 0, and writes to 0x28 or to unlisted offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Output-data register |
| pad_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Merged interrupt request |

## Verification
Two actions can land on the same cycle: a clear write for an edge pin, and the detection of a fresh edge on that same pin. The bench raises the pad at a falling clock edge and waits through the two synchroniser stages. It then places the clear write in exactly the cycle in which the detector sees the transition, so both meet at one rising edge. Reading the status afterwards must show the bit still set; losing that edge is counted as a failure. A separate pair of tests clears one pin while a neighbour stays latched, which shows that a clear touches only the bits written as 1.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_ADDR_W = 7;
  localparam int unsigned BUS_W      = 32;

  typedef logic [REG_ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t OFS_MODE   = 7'h00;
  localparam reg_addr_t OFS_DIR    = 7'h04;
  localparam reg_addr_t OFS_DOUT   = 7'h08;
  localparam reg_addr_t OFS_DIN    = 7'h0C;
  localparam reg_addr_t OFS_STAT   = 7'h10;
  localparam reg_addr_t OFS_CLR    = 7'h14;
  localparam reg_addr_t OFS_MASK   = 7'h18;
  localparam reg_addr_t OFS_UNMASK = 7'h1C;
  localparam reg_addr_t OFS_POL    = 7'h20;
  localparam reg_addr_t OFS_EDGE   = 7'h24;
  localparam reg_addr_t OFS_DUAL   = 7'h4C;

  typedef struct packed {
    logic mode;
    logic dir;
    logic dout;
    logic clr;
    logic mask;
    logic unmask;
    logic pol;
    logic edge_sel;
    logic dual;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] irq_mode,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] neg_pol,
  input  logic [W-1:0] dual_edge,
  input  logic [W-1:0] clr_req,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] hit;
  logic [W-1:0] armed;
  logic [W-1:0] set_v;
  logic [W-1:0] level_v;

  assign armed = irq_mode & edge_mode;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise_w;
    logic fall_w;
    assign rise_w = pin_s[i] & ~prev_q[i];
    assign fall_w = ~pin_s[i] & prev_q[i];
    assign hit[i] = dual_edge[i] ? (rise_w | fall_w)
                                 : (neg_pol[i] ? fall_w : rise_w);
  end

  assign set_v = armed & hit;

  // a fresh edge outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= pin_s;
      lat_q  <= (set_v | (lat_q & ~clr_req)) & armed;
    end
  end

  assign level_v = irq_mode & ~edge_mode & (pin_s ^ neg_pol);
  assign status  = (lat_q & armed) | level_v;

  p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(set_v)) == $past(set_v)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(clr_req & ~set_v)) == '0));

  p_dual_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(armed & dual_edge & (pin_s ^ prev_q)))
              == $past(armed & dual_edge & (pin_s ^ prev_q))));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  reg_addr_t        bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [W-1:0]     pin_s,
  input  logic [W-1:0]     status,
  output logic [W-1:0]     mode_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     edge_q,
  output logic [W-1:0]     dual_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     clr_req
);
  wr_strobe_t   stb;
  logic         wr_en;
  logic [W-1:0] wd;
  logic [W-1:0] drive;
  logic [W-1:0] din_view;

  assign wr_en = bus_sel & bus_wr;
  assign wd    = bus_wdata[W-1:0];

  always_comb begin
    stb          = '0;
    stb.mode     = wr_en && (bus_addr == OFS_MODE);
    stb.dir      = wr_en && (bus_addr == OFS_DIR);
    stb.dout     = wr_en && (bus_addr == OFS_DOUT);
    stb.clr      = wr_en && (bus_addr == OFS_CLR);
    stb.mask     = wr_en && (bus_addr == OFS_MASK);
    stb.unmask   = wr_en && (bus_addr == OFS_UNMASK);
    stb.pol      = wr_en && (bus_addr == OFS_POL);
    stb.edge_sel = wr_en && (bus_addr == OFS_EDGE);
    stb.dual     = wr_en && (bus_addr == OFS_DUAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
    end else begin
      if (stb.mode)     mode_q <= wd;
      if (stb.dir)      dir_q  <= wd;
      if (stb.dout)     dout_q <= wd;
      if (stb.pol)      pol_q  <= wd;
      if (stb.edge_sel) edge_q <= wd;
      if (stb.dual)     dual_q <= wd;
      if (stb.mask)     mask_q <= mask_q & wd;
      else if (stb.unmask) mask_q <= mask_q | wd;
    end
  end

  assign clr_req  = stb.clr ? wd : '0;
  assign drive    = dir_q & ~mode_q;
  assign din_view = (drive & dout_q) | (~drive & pin_s);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_MODE: bus_rdata[W-1:0] = mode_q;
      OFS_DIR:  bus_rdata[W-1:0] = dir_q;
      OFS_DOUT: bus_rdata[W-1:0] = dout_q;
      OFS_DIN:  bus_rdata[W-1:0] = din_view;
      OFS_STAT: bus_rdata[W-1:0] = status;
      OFS_MASK: bus_rdata[W-1:0] = mask_q;
      OFS_POL:  bus_rdata[W-1:0] = pol_q;
      OFS_EDGE: bus_rdata[W-1:0] = edge_q;
      OFS_DUAL: bus_rdata[W-1:0] = dual_q;
      default:  bus_rdata = '0;
    endcase
  end

  p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.mask |=> ((mask_q & ~$past(wd)) == '0));

  p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.unmask |=> ((mask_q & $past(wd)) == $past(wd)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  output logic                  irq
);
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] mode_q, dir_q, dout_q, pol_q, edge_q, dual_q, mask_q;
  logic [NPINS-1:0] clr_req;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_s)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_s     (pin_s),
    .status    (status),
    .mode_q    (mode_q),
    .dir_q     (dir_q),
    .dout_q    (dout_q),
    .pol_q     (pol_q),
    .edge_q    (edge_q),
    .dual_q    (dual_q),
    .mask_q    (mask_q),
    .clr_req   (clr_req)
  );

  gpio_irq_sense #(.W(NPINS)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s     (pin_s),
    .irq_mode  (mode_q),
    .edge_mode (edge_q),
    .neg_pol   (pol_q),
    .dual_edge (dual_q),
    .clr_req   (clr_req),
    .status    (status)
  );

  assign pad_out = dout_q;
  assign pad_oe  = dir_q & ~mode_q;
  assign irq     = |(status & mask_q);

  p_io_no_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mode_q) == '0));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (mask_q != '0));

  p_irq_pin_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & mode_q) == '0));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  import gpio_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank #(.NPINS(32)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
    end
  endtask

  // all tasks start and end just after a falling clock edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pad_in = '0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    foreach (OFS_LIST[k]) begin
      rd(OFS_LIST[k], v);
      chk("R1", "register after reset", v, 32'h0);
    end
    chk("R1", "pad_oe after reset", pad_oe, 32'h0);
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
  endtask

  localparam logic [6:0] OFS_LIST [11] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10,
    7'h14, 7'h18, 7'h1C, 7'h20, 7'h24, 7'h4C};

  task automatic t_io();
    logic [31:0] v;
    do_reset();
    wr(OFS_DOUT, 32'h0000_00A5);
    chk("R2", "pad_out while input", pad_out, 32'h0000_00A5);
    chk("R2", "no drive while input", pad_oe, 32'h0);
    wr(OFS_DIR, 32'h0000_00FF);
    chk("R2", "drive after direction", pad_oe, 32'h0000_00FF);
    chk("R2", "held data on pad", pad_out, 32'h0000_00A5);
    pad_in = 32'hFFFF_0000;
    wait_cyc(1);
    rd(OFS_DIN, v);
    chk("R3", "one edge not yet visible", v, 32'h0000_00A5);
    wait_cyc(1);
    rd(OFS_DIN, v);
    chk("R3", "readback mixes data and pad", v, 32'hFFFF_00A5);
    wr(OFS_MODE, 32'h0000_0001);
    chk("R2", "interrupt pin not driven", pad_oe, 32'h0000_00FE);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    wr(OFS_EDGE, 32'h2);
    wr(OFS_MODE, 32'h2);
    pad_in[1] = 1'b1; wait_cyc(4);
    rd(OFS_STAT, v); chk("R4", "rising sets", v, 32'h2);
    wr(OFS_CLR, 32'h2);
    rd(OFS_STAT, v); chk("R7", "clear one", v, 32'h0);
    pad_in[1] = 1'b0; wait_cyc(4);
    rd(OFS_STAT, v); chk("R4", "falling ignored at pol 0", v, 32'h0);
    wr(OFS_POL, 32'h2);
    pad_in[1] = 1'b1; wait_cyc(4);
    rd(OFS_STAT, v); chk("R4", "rising ignored at pol 1", v, 32'h0);
    pad_in[1] = 1'b0; wait_cyc(4);
    rd(OFS_STAT, v); chk("R4", "falling sets at pol 1", v, 32'h2);
  endtask

  task automatic t_dual();
    logic [31:0] v;
    do_reset();
    wr(OFS_EDGE, 32'h4);
    wr(OFS_DUAL, 32'h4);
    wr(OFS_MODE, 32'h4);
    pad_in[2] = 1'b1; wait_cyc(4);
    rd(OFS_STAT, v); chk("R5", "dual rising", v, 32'h4);
    wr(OFS_CLR, 32'h4);
    pad_in[2] = 1'b0; wait_cyc(4);
    rd(OFS_STAT, v); chk("R5", "dual falling", v, 32'h4);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(OFS_MODE, 32'h8);
    wait_cyc(1);
    rd(OFS_STAT, v); chk("R6", "low pad inactive", v, 32'h0);
    pad_in[3] = 1'b1; wait_cyc(3);
    rd(OFS_STAT, v); chk("R6", "high pad active", v, 32'h8);
    wr(OFS_CLR, 32'h8);
    wait_cyc(1);
    rd(OFS_STAT, v); chk("R6", "clear does not stick", v, 32'h8);
    wr(OFS_POL, 32'h8);
    rd(OFS_STAT, v); chk("R6", "inverted polarity", v, 32'h0);
    pad_in[3] = 1'b0; wait_cyc(3);
    rd(OFS_STAT, v); chk("R6", "active low", v, 32'h8);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    do_reset();
    wr(OFS_EDGE, 32'h30);
    wr(OFS_MODE, 32'h30);
    pad_in[5:4] = 2'b11; wait_cyc(4);
    rd(OFS_STAT, v); chk("R7", "two latched", v, 32'h30);
    wr(OFS_CLR, 32'h10);
    rd(OFS_STAT, v); chk("R7", "only written bit cleared", v, 32'h20);
    wr(OFS_CLR, 32'h0);
    rd(OFS_STAT, v); chk("R7", "zero write no effect", v, 32'h20);
    pad_in[5] = 1'b0; wait_cyc(4);
    wr(OFS_CLR, 32'h20);
    rd(OFS_STAT, v); chk("R7", "cleared before collision", v, 32'h0);
    pad_in[5] = 1'b1;
    wait_cyc(2);
    wr(OFS_CLR, 32'h20);
    rd(OFS_STAT, v); chk("R7", "edge wins over clear", v, 32'h20);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    wr(OFS_EDGE, 32'h40);
    wr(OFS_MODE, 32'h40);
    pad_in[6] = 1'b1; wait_cyc(4);
    chk("R9", "masked status no irq", {31'h0, irq}, 32'h0);
    wr(OFS_UNMASK, 32'hC0);
    rd(OFS_MASK, v); chk("R8", "unmask sets", v, 32'hC0);
    chk("R9", "irq on", {31'h0, irq}, 32'h1);
    wr(OFS_MASK, 32'hFFFF_FF7F);
    rd(OFS_MASK, v); chk("R8", "zero bits clear ones keep", v, 32'h40);
    chk("R9", "irq stays", {31'h0, irq}, 32'h1);
    wr(OFS_MASK, 32'h0);
    chk("R9", "irq off when masked", {31'h0, irq}, 32'h0);
    wr(OFS_UNMASK, 32'h40);
    wr(OFS_CLR, 32'h40);
    chk("R9", "irq off when cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    do_reset();
    wr(OFS_EDGE, 32'h80);
    pad_in[7] = 1'b1; wait_cyc(4);
    pad_in[7] = 1'b0; wait_cyc(4);
    rd(OFS_STAT, v); chk("R10", "io pin no status", v, 32'h0);
    wr(7'h28, 32'hFFFF_FFFF);
    wr(7'h30, 32'hFFFF_FFFF);
    rd(7'h28, v); chk("R10", "filter offset reads 0", v, 32'h0);
    rd(7'h30, v); chk("R10", "unlisted reads 0", v, 32'h0);
    rd(OFS_MODE, v); chk("R10", "mode untouched", v, 32'h0);
    wr(OFS_UNMASK, 32'h1);
    rd(OFS_UNMASK, v); chk("R10", "unmask reads 0", v, 32'h0);
    wr(OFS_CLR, 32'h1);
    rd(OFS_CLR, v); chk("R10", "clear reads 0", v, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_io();
    t_edge();
    t_dual();
    t_level();
    t_clear();
    t_mask();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule